// File: doc/BRIEF.md
# Per-Cycle Variable-Period Test Sequencer

This block drives a device under test one test cycle at a time. Each cycle arrives as a pattern word that carries a period selector, the primary input values, a single serial scan bit and the expected device response. The sequencer applies the inputs at the start of the cycle. After a programmable guard gap it raises the test clock, which stays high for half the period. On the last system tick of the period it compares the device output with the expected value. The period of each cycle comes from one of four programmable period registers, so fast cycles and slow cycles can be mixed within one run. A fixed-period mode forces every cycle onto the longest programmed period, which gives a baseline for comparison.

Period registers count system clock ticks and never hold less than a configured floor. A combinational helper maps a required tick count to the shortest programmed period that covers it. This helper is used when patterns are assigned their selectors. A running tick total and a saturating mismatch counter let a test flow compare runs and judge them.

Top module: `vp_test_seq`

## Requirements
- R1: There are four period registers, indexed 0 to 3. Each resets to MIN_PERIOD ticks. A write below MIN_PERIOD stores MIN_PERIOD, and any other write stores the written value.
- R2: When sync_mode_i is 0, an accepted pattern runs for exactly the number of ticks held in the register named by its 2-bit selector. cmp_valid_o pulses high for one cycle, P cycles after the accepting clock edge.
- R3: When sync_mode_i is 1, the selector is ignored and the cycle uses the largest of the four registers.
- R4: dut_pi_o and dut_scan_o take the pattern's values on the edge that accepts it. They hold those values for the whole period.
- R5: With effective gap G and period P, tck_o is low for ticks 0 to G-1. It is high for floor(P/2) ticks starting at tick G, and low for the rest of the period.
- R6: The effective gap is guard_i when guard_i < floor(P/2). Otherwise it is floor(P/2)-1.
- R7: dut_po_i is sampled on the last tick of the period. mismatch_o then shows (sampled value != expected value) while cmp_valid_o is high, and holds that value until the next compare.
- R8: err_cnt_o increments by one on each mismatch and saturates at all ones.
- R9: total_ticks_o grows by P for each completed cycle of P ticks.
- R10: pat_ready_o is high when idle or on the final tick of a period, and low otherwise. A pattern offered on the final tick starts the next period with no idle tick.
- R11: fit_sel_o and fit_ticks_o name the smallest register value that is at least fit_need_i, with the lowest index winning a tie, and fit_ok_o is 1. If no register covers the need, fit_ok_o is 0 and the largest register is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Period register write strobe |
| cfg_idx_i | input | 2 | Period register index |
| cfg_val_i | input | TICK_W | Period value in ticks |
| guard_i | input | TICK_W | Requested input-to-clock guard gap in ticks |
| sync_mode_i | input | 1 | 1 = every cycle uses the largest period |
| fit_need_i | input | TICK_W | Required ticks for the round-up helper |
| fit_sel_o | output | 2 | Helper: chosen register index |
| fit_ticks_o | output | TICK_W | Helper: chosen period |
| fit_ok_o | output | 1 | Helper: a register covers the need |
| pat_valid_i | input | 1 | Pattern offered |
| pat_ready_o | output | 1 | Pattern taken on this edge if valid |
| pat_sel_i | input | 2 | Period selector |
| pat_pi_i | input | NUM_PI | Primary input values |
| pat_scan_i | input | 1 | Serial scan bit for this cycle |
| pat_exp_i | input | NUM_PO | Expected device output |
| dut_pi_o | output | NUM_PI | Primary inputs to the device |
| dut_scan_o | output | 1 | Scan data to the device |
| tck_o | output | 1 | Test clock |
| dut_po_i | input | NUM_PO | Device output |
| cmp_valid_o | output | 1 | One-cycle pulse after each compare |
| mismatch_o | output | 1 | Result of the latest compare |
| err_cnt_o | output | ERR_W | Saturating mismatch count |
| total_ticks_o | output | TOTAL_W | Ticks spent in test cycles |

## Verification
The bench runs a model device that captures a function of its inputs on the rising test-clock edge. A sequencer that samples the output before the end of the period, or that raises the clock before the guard gap, therefore compares against stale data and reports false mismatches. The bench sweeps the guard across every value for an even and an odd period. A gap clamp that is off by one moves the first high tick or lets the high phase spill past the period. An odd period exposes a high time rounded the wrong way. It writes values below the floor and expects the floor back, which catches a missing clamp. It also checks that fixed-period mode ignores the selector. It drives enough failures to pin the error counter at its ceiling, which catches a counter that wraps. The round-up helper is swept over every need value against unsorted registers, so a selector that picks the first fit rather than the smallest fit returns a wrong index.

// File: rtl/vpts_pkg.sv
package vpts_pkg;
  localparam int NUM_PER = 4;
  localparam int SEL_W   = 2;
  typedef logic [SEL_W-1:0] per_sel_t;
endpackage

// File: rtl/vpts_period_bank.sv
module vpts_period_bank
  import vpts_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int MIN_PERIOD = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  per_sel_t          wr_idx_i,
  input  logic [TICK_W-1:0] wr_val_i,
  input  per_sel_t          rd_idx_i,
  output logic [TICK_W-1:0] rd_val_o,
  output per_sel_t          max_idx_o,
  input  logic [TICK_W-1:0] need_i,
  output per_sel_t          fit_idx_o,
  output logic [TICK_W-1:0] fit_val_o,
  output logic              fit_ok_o
);
  localparam logic [TICK_W-1:0] FLOOR = TICK_W'(MIN_PERIOD);

  logic [TICK_W-1:0] per_q [NUM_PER];
  logic [TICK_W-1:0] max_val;

  for (genvar g = 0; g < NUM_PER; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        per_q[g] <= FLOOR;
      else if (wr_en_i && wr_idx_i == per_sel_t'(g))
        per_q[g] <= (wr_val_i < FLOOR) ? FLOOR : wr_val_i;
    end
  end

  assign rd_val_o = per_q[rd_idx_i];

  // largest register, lowest index on tie
  always_comb begin
    max_idx_o = '0;
    max_val   = per_q[0];
    for (int i = 1; i < NUM_PER; i++) begin
      if (per_q[i] > max_val) begin
        max_val   = per_q[i];
        max_idx_o = per_sel_t'(i);
      end
    end
  end

  // round a need up to the tightest covering period
  always_comb begin
    fit_ok_o  = 1'b0;
    fit_idx_o = '0;
    fit_val_o = '0;
    for (int i = 0; i < NUM_PER; i++) begin
      if (per_q[i] >= need_i && (!fit_ok_o || per_q[i] < fit_val_o)) begin
        fit_ok_o  = 1'b1;
        fit_idx_o = per_sel_t'(i);
        fit_val_o = per_q[i];
      end
    end
    if (!fit_ok_o) begin
      fit_idx_o = max_idx_o;
      fit_val_o = max_val;
    end
  end
endmodule

// File: rtl/vpts_cycle_timer.sv
module vpts_cycle_timer #(
  parameter int TICK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TICK_W-1:0] per_i,
  input  logic [TICK_W-1:0] guard_i,
  output logic              active_o,
  output logic              last_o,
  output logic              tck_o,
  output logic [TICK_W-1:0] cnt_o,
  output logic [TICK_W-1:0] per_o,
  output logic [TICK_W-1:0] gap_o
);
  logic [TICK_W-1:0] half_in, gap_in;
  logic [TICK_W-1:0] cnt_q, per_q, gap_q, half_q;
  logic              active_q;

  assign half_in = per_i >> 1;
  assign gap_in  = (guard_i >= half_in) ? half_in - 1'b1 : guard_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      per_q    <= '0;
      gap_q    <= '0;
      half_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      per_q    <= per_i;
      gap_q    <= gap_in;
      half_q   <= half_in;
    end else if (last_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o   = active_q && (cnt_q == per_q - 1'b1);
  assign tck_o    = active_q && (cnt_q >= gap_q) && ((cnt_q - gap_q) < half_q);
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign gap_o    = gap_q;
endmodule

// File: rtl/vpts_result.sv
module vpts_result #(
  parameter int NUM_PO = 4,
  parameter int ERR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [NUM_PO-1:0] po_i,
  input  logic [NUM_PO-1:0] exp_i,
  output logic              done_o,
  output logic              mismatch_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic miss;
  assign miss = (po_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
      err_cnt_o  <= '0;
    end else begin
      done_o <= sample_i;
      if (sample_i) begin
        mismatch_o <= miss;
        if (miss && err_cnt_o != '1) err_cnt_o <= err_cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vp_test_seq.sv
module vp_test_seq
  import vpts_pkg::*;
#(
  parameter int NUM_PI     = 4,
  parameter int NUM_PO     = 4,
  parameter int TICK_W     = 8,
  parameter int MIN_PERIOD = 4,
  parameter int ERR_W      = 8,
  parameter int TOTAL_W    = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_idx_i,
  input  logic [TICK_W-1:0]  cfg_val_i,
  input  logic [TICK_W-1:0]  guard_i,
  input  logic               sync_mode_i,
  input  logic [TICK_W-1:0]  fit_need_i,
  output logic [1:0]         fit_sel_o,
  output logic [TICK_W-1:0]  fit_ticks_o,
  output logic               fit_ok_o,
  input  logic               pat_valid_i,
  output logic               pat_ready_o,
  input  logic [1:0]         pat_sel_i,
  input  logic [NUM_PI-1:0]  pat_pi_i,
  input  logic               pat_scan_i,
  input  logic [NUM_PO-1:0]  pat_exp_i,
  output logic [NUM_PI-1:0]  dut_pi_o,
  output logic               dut_scan_o,
  output logic               tck_o,
  input  logic [NUM_PO-1:0]  dut_po_i,
  output logic               cmp_valid_o,
  output logic               mismatch_o,
  output logic [ERR_W-1:0]   err_cnt_o,
  output logic [TOTAL_W-1:0] total_ticks_o
);
  per_sel_t          sel_eff, max_idx;
  logic [TICK_W-1:0] sel_per, cnt, per_cur, gap_cur;
  logic              active, last, accept;
  logic [NUM_PI-1:0] pi_q;
  logic              scan_q;
  logic [NUM_PO-1:0] exp_q;
  logic [TOTAL_W-1:0] total_q;

  assign pat_ready_o = !active || last;
  assign accept      = pat_valid_i && pat_ready_o;
  assign sel_eff     = sync_mode_i ? max_idx : per_sel_t'(pat_sel_i);

  vpts_period_bank #(.TICK_W(TICK_W), .MIN_PERIOD(MIN_PERIOD)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_idx_i  (per_sel_t'(cfg_idx_i)),
    .wr_val_i  (cfg_val_i),
    .rd_idx_i  (sel_eff),
    .rd_val_o  (sel_per),
    .max_idx_o (max_idx),
    .need_i    (fit_need_i),
    .fit_idx_o (fit_sel_o),
    .fit_val_o (fit_ticks_o),
    .fit_ok_o  (fit_ok_o)
  );

  vpts_cycle_timer #(.TICK_W(TICK_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .per_i    (sel_per),
    .guard_i  (guard_i),
    .active_o (active),
    .last_o   (last),
    .tck_o    (tck_o),
    .cnt_o    (cnt),
    .per_o    (per_cur),
    .gap_o    (gap_cur)
  );

  vpts_result #(.NUM_PO(NUM_PO), .ERR_W(ERR_W)) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (last),
    .po_i       (dut_po_i),
    .exp_i      (exp_q),
    .done_o     (cmp_valid_o),
    .mismatch_o (mismatch_o),
    .err_cnt_o  (err_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pi_q    <= '0;
      scan_q  <= 1'b0;
      exp_q   <= '0;
      total_q <= '0;
    end else begin
      if (accept) begin
        pi_q   <= pat_pi_i;
        scan_q <= pat_scan_i;
        exp_q  <= pat_exp_i;
      end
      if (active) total_q <= total_q + 1'b1;
    end
  end

  assign dut_pi_o      = pi_q;
  assign dut_scan_o    = scan_q;
  assign total_ticks_o = total_q;
endmodule

// File: rtl/vpts_chk.sv
module vpts_chk #(
  parameter int NUM_PI     = 4,
  parameter int TICK_W     = 8,
  parameter int MIN_PERIOD = 4,
  parameter int ERR_W      = 8,
  parameter int TOTAL_W    = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               active_i,
  input logic               last_i,
  input logic [TICK_W-1:0]  cnt_i,
  input logic [TICK_W-1:0]  per_i,
  input logic [TICK_W-1:0]  gap_i,
  input logic               tck_o,
  input logic               pat_ready_o,
  input logic [NUM_PI-1:0]  dut_pi_o,
  input logic               dut_scan_o,
  input logic               cmp_valid_o,
  input logic [ERR_W-1:0]   err_cnt_o,
  input logic [TOTAL_W-1:0] total_ticks_o,
  input logic [TICK_W-1:0]  fit_need_i,
  input logic [TICK_W-1:0]  fit_ticks_o,
  input logic               fit_ok_o
);
  a_r1_period_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> per_i >= TICK_W'(MIN_PERIOD));
  a_r4_inputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i != '0) |-> ($stable(dut_pi_o) && $stable(dut_scan_o)));
  a_r5_low_in_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i < gap_i) |-> !tck_o);
  a_r6_gap_below_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> gap_i < (per_i >> 1));
  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_o |-> $past(last_i));
  a_r8_err_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> err_cnt_o >= $past(err_cnt_o));
  a_r9_total_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> total_ticks_o >= $past(total_ticks_o));
  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !last_i) |-> !pat_ready_o);
  a_r11_fit_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fit_ok_o |-> fit_ticks_o >= fit_need_i);
endmodule

bind vp_test_seq vpts_chk #(
  .NUM_PI(NUM_PI), .TICK_W(TICK_W), .MIN_PERIOD(MIN_PERIOD),
  .ERR_W(ERR_W), .TOTAL_W(TOTAL_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .active_i      (active),
  .last_i        (last),
  .cnt_i         (cnt),
  .per_i         (per_cur),
  .gap_i         (gap_cur),
  .tck_o         (tck_o),
  .pat_ready_o   (pat_ready_o),
  .dut_pi_o      (dut_pi_o),
  .dut_scan_o    (dut_scan_o),
  .cmp_valid_o   (cmp_valid_o),
  .err_cnt_o     (err_cnt_o),
  .total_ticks_o (total_ticks_o),
  .fit_need_i    (fit_need_i),
  .fit_ticks_o   (fit_ticks_o),
  .fit_ok_o      (fit_ok_o)
);

// File: tb/sim_vp_test_seq.sv
`timescale 1ns/1ps
module sim_vp_test_seq;
  localparam int NPI = 4, NPO = 4, TW = 8, MINP = 4, EW = 3, TOTW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_we = 0; logic [1:0] cfg_idx = 0; logic [TW-1:0] cfg_val = 0;
  logic [TW-1:0] guard = 0; logic sync_mode = 0; logic [TW-1:0] need = 0;
  logic [1:0] fit_sel; logic [TW-1:0] fit_ticks; logic fit_ok;
  logic pat_valid = 0, pat_ready; logic [1:0] pat_sel = 0;
  logic [NPI-1:0] pat_pi = 0; logic pat_scan = 0; logic [NPO-1:0] pat_exp = 0;
  logic [NPI-1:0] dut_pi; logic dut_scan, tck;
  logic [NPO-1:0] po_q;
  logic cmp_valid, mismatch; logic [EW-1:0] err_cnt; logic [TOTW-1:0] total;

  int checks = 0, errors = 0;
  int per_mdl [4];
  int err_mdl = 0;

  // model device: captures pi ^ scan on the rising test clock
  always @(posedge tck or negedge rst_n)
    if (!rst_n) po_q <= '0;
    else po_q <= dut_pi ^ {NPO{dut_scan}};

  vp_test_seq #(.NUM_PI(NPI), .NUM_PO(NPO), .TICK_W(TW), .MIN_PERIOD(MINP),
                .ERR_W(EW), .TOTAL_W(TOTW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_val_i(cfg_val), .guard_i(guard), .sync_mode_i(sync_mode),
    .fit_need_i(need), .fit_sel_o(fit_sel), .fit_ticks_o(fit_ticks), .fit_ok_o(fit_ok),
    .pat_valid_i(pat_valid), .pat_ready_o(pat_ready), .pat_sel_i(pat_sel),
    .pat_pi_i(pat_pi), .pat_scan_i(pat_scan), .pat_exp_i(pat_exp),
    .dut_pi_o(dut_pi), .dut_scan_o(dut_scan), .tck_o(tck), .dut_po_i(po_q),
    .cmp_valid_o(cmp_valid), .mismatch_o(mismatch), .err_cnt_o(err_cnt),
    .total_ticks_o(total));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_per(input int idx, input int val);
    @(negedge clk); cfg_we = 1; cfg_idx = 2'(idx); cfg_val = TW'(val);
    @(negedge clk); cfg_we = 0;
    per_mdl[idx] = (val < MINP) ? MINP : val;
  endtask

  // runs one pattern; exp_per is the expected period length in ticks
  task automatic run_pat(input int sel, input int pi, input int scan,
                         input bit bad, input int exp_per);
    int half, gap, first, highs, t0, k, ready_bad;
    logic [NPO-1:0] good, e;
    bit mis;
    half = exp_per / 2;
    gap  = (int'(guard) >= half) ? half - 1 : int'(guard);
    good = NPO'(pi) ^ {NPO{scan[0]}};
    e    = bad ? ~good : good;
    mis  = bad;
    @(negedge clk);
    t0 = int'(total);
    pat_valid = 1; pat_sel = 2'(sel); pat_pi = NPI'(pi); pat_scan = scan[0]; pat_exp = e;
    @(posedge clk);
    @(negedge clk); pat_valid = 0;
    first = -1; highs = 0; ready_bad = 0;
    for (k = 0; k < 400; k++) begin
      if (k > 0) @(negedge clk);
      if (cmp_valid) break;
      if (k == 0) chk(dut_pi == NPI'(pi) && dut_scan == scan[0], "R4 pi/scan applied", int'(dut_pi), pi);
      if (dut_pi != NPI'(pi)) ready_bad = ready_bad + 100;
      if (tck) begin highs++; if (first < 0) first = k; end
      if (pat_ready != (k == exp_per - 1)) ready_bad++;
    end
    chk(k == exp_per, sync_mode ? "R3 sync period" : "R2 period length", k, exp_per);
    chk(first == gap, "R5/R6 first high tick", first, gap);
    chk(highs == half, "R5 high ticks", highs, half);
    chk(ready_bad == 0, "R10/R4 ready and hold", ready_bad, 0);
    chk(mismatch == mis, "R7 compare result", int'(mismatch), int'(mis));
    if (mis && err_mdl < (1 << EW) - 1) err_mdl++;
    chk(int'(err_cnt) == err_mdl, "R8 error count", int'(err_cnt), err_mdl);
    chk(int'(total) == t0 + exp_per, "R9 tick total", int'(total), t0 + exp_per);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) per_mdl[i] = MINP;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tck && pat_ready && !cmp_valid && err_cnt == 0 && total == 0,
        "R10 reset state", int'({tck, pat_ready, cmp_valid}), 2);

    // R1: reset value, then clamping
    run_pat(2, 5, 0, 0, MINP);
    wr_per(0, 2);
    run_pat(0, 3, 1, 0, MINP);
    wr_per(1, 0);
    run_pat(1, 9, 1, 1, MINP);
    wr_per(3, MINP);
    run_pat(3, 6, 0, 0, MINP);

    // R2: unsorted periods, every selector
    wr_per(0, 9); wr_per(1, 6); wr_per(2, 14); wr_per(3, 11);
    guard = 2;
    for (int s = 0; s < 4; s++) run_pat(s, s * 3 + 1, s & 1, s == 2, per_mdl[s]);

    // R5, R6: full guard sweep on even and odd periods
    for (int g = 0; g < 10; g++) begin
      guard = TW'(g);
      run_pat(2, g, g & 1, 0, 14);
      run_pat(0, 15 - g, ~g & 1, 0, 9);
    end

    // R3: selector ignored in sync mode
    sync_mode = 1; guard = 1;
    for (int s = 0; s < 4; s++) run_pat(s, s + 8, s & 1, 0, 14);
    sync_mode = 0;

    // R8: drive the counter into saturation
    for (int i = 0; i < 10; i++) run_pat(1, i, i & 1, 1, 6);
    chk(err_cnt == '1, "R8 saturated", int'(err_cnt), (1 << EW) - 1);
    run_pat(1, 2, 0, 0, 6);

    // R10: back-to-back pattern accepted on the last tick
    begin : b2b
      int gapc;
      @(negedge clk);
      pat_valid = 1; pat_sel = 1; pat_pi = 4'h3; pat_scan = 0; pat_exp = 4'h3;
      @(posedge clk);
      @(negedge clk); pat_sel = 3; pat_pi = 4'h5; pat_exp = 4'h5;
      while (!pat_ready) @(negedge clk);
      @(negedge clk); pat_valid = 0;
      gapc = 0;
      while (!cmp_valid) @(negedge clk);
      @(negedge clk);
      while (!cmp_valid && gapc < 100) begin gapc++; @(negedge clk); end
      chk(gapc == per_mdl[3] - 1, "R10 no idle tick between cycles", gapc, per_mdl[3] - 1);
      chk(!mismatch, "R7 second back-to-back compare", int'(mismatch), 0);
    end

    // R11: round-up helper sweep
    for (int n = 0; n < 20; n++) begin
      int best, bsel, mx, msel;
      best = -1; bsel = 0; mx = per_mdl[0]; msel = 0;
      for (int i = 0; i < 4; i++) begin
        if (per_mdl[i] >= n && (best < 0 || per_mdl[i] < best)) begin best = per_mdl[i]; bsel = i; end
        if (per_mdl[i] > mx) begin mx = per_mdl[i]; msel = i; end
      end
      @(negedge clk); need = TW'(n);
      @(negedge clk);
      if (best < 0)
        chk(!fit_ok && int'(fit_ticks) == mx && int'(fit_sel) == msel, "R11 no fit", int'(fit_ticks), mx);
      else
        chk(fit_ok && int'(fit_ticks) == best && int'(fit_sel) == bsel, "R11 round up", int'(fit_sel), bsel);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule